// File: doc/BRIEF.md
# DLL Delay Calibration Sequencer

This block drives the calibration of a delay-locked loop that sits beside a card interface. When software selects a double-data-rate timing mode and pulses start, the sequencer switches the data path into DDR mode, programs the DLL with a fixed control word and then reads the DLL lock value over and over until the DLL reports that it has locked. From the lock value it derives two delay settings, a pad delay and a read-sample delay, and writes them into the delay register. If the DLL never reports lock within a time budget, the sequencer gives up and raises a sticky timeout flag without touching the delay register.

All traffic toward the DLL goes over a small register-style bus with one-cycle write strobes, a read strobe whose data returns on the following cycle, and a two-bit register select. Register 0 is the data-mode select, register 1 the DLL control word, register 2 the lock value (read only) and register 3 the delay register. The timeout budget is given in microseconds together with the clock frequency in MHz; the block turns these into a cycle count.

Top module: `dll_cal_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `timeout_o`, `bus_wr_o` and `bus_rd_o` are all 0.
- R2: A start pulse while `ddr_mode_i` is 0 is ignored: no bus access follows, the block stays idle and `done_o`/`timeout_o` keep their values.
- R3: The first bus access of an accepted sequence is a write to register 0 with write data 1 (bit 0 = 1 selects DDR data mode).
- R4: The next access writes register 1 with the DLL control word 0x3F0101C8: lock time 0xC8 in bits 7:0, increment 1 in bits 15:8, start value 1 in bits 23:16, clock mode 1 in bit 24, start bit 1 in bit 25, bypass time 0xF in bits 29:26.
- R5: After the control write the block reads register 2 repeatedly; read data returns the cycle after `bus_rd_o`, and polling continues while its bit 8 (done) is 0.
- R6: Once a read returns bit 8 = 1, the block writes register 3 with bits 7:0 = lock bits 7:1 (zero-extended), bits 15:8 = that value plus one, all higher bits 0; it then returns to idle with `done_o` = 1.
- R7: If lock is not seen within TIMEOUT_US x CLK_MHZ cycles of polling, `timeout_o` is set, register 3 is never written, and the block returns to idle.
- R8: An accepted start clears both `done_o` and `timeout_o`; both flags are otherwise sticky, and they are never 1 together.
- R9: Start pulses that arrive while a sequence is running are ignored; the running sequence completes with exactly one mode-select write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| ddr_mode_i | input | 1 | 1 when the selected timing is a DDR mode |
| bus_wr_o | output | 1 | Register write strobe |
| bus_rd_o | output | 1 | Register read strobe |
| bus_addr_o | output | 2 | Register select: 0 mode, 1 control, 2 lock value, 3 delay |
| bus_wdata_o | output | DATA_W | Write data |
| bus_rdata_i | input | 9 | Lock-value read data, bit 8 = done, bits 7:0 = value |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sticky: delay register written |
| timeout_o | output | 1 | Sticky: lock not seen in time |

## Verification
The bench builds the block with CLK_MHZ = 1 and TIMEOUT_US = 40, so the polling budget shrinks from hundreds of thousands of cycles to forty. That brings the timeout path, its exact cycle window and the recovery through a fresh start within a short run, while lock-value extremes (all ones, only bit 0 set) and locks after zero or several polls cover the delay arithmetic and the polling loop.

// File: rtl/dll_cal_pkg.sv
package dll_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_MODE, ST_CTRL, ST_POLL, ST_CHECK, ST_DELAY
  } seq_state_t;

  localparam logic [1:0] REG_MODE  = 2'd0;
  localparam logic [1:0] REG_CTRL  = 2'd1;
  localparam logic [1:0] REG_LOCK  = 2'd2;
  localparam logic [1:0] REG_DELAY = 2'd3;

  localparam logic [7:0] CW_LOCK_TIME = 8'hC8;
  localparam logic [7:0] CW_INCR      = 8'h01;
  localparam logic [7:0] CW_START_VAL = 8'h01;
  localparam logic       CW_CLK_MODE  = 1'b1;
  localparam logic       CW_START_BIT = 1'b1;
  localparam logic [3:0] CW_BYPASS    = 4'hF;

  localparam logic [31:0] CTRL_WORD = {2'b00, CW_BYPASS, CW_START_BIT, CW_CLK_MODE,
                                       CW_START_VAL, CW_INCR, CW_LOCK_TIME};
endpackage

// File: rtl/dll_poll_timer.sv
module dll_poll_timer #(
  parameter int LIMIT = 400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i || (run_i && (cnt_q != TERM));
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == TERM);

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TERM);
endmodule

// File: rtl/dll_delay_calc.sv
module dll_delay_calc #(
  parameter int FIELD_W = 8
) (
  input  logic [FIELD_W-2:0]   pad_i,
  output logic [2*FIELD_W-1:0] word_o
);
  logic [FIELD_W-1:0] pad_f, rd_f;

  always_comb begin
    pad_f  = {1'b0, pad_i};
    rd_f   = pad_f + 1'b1;
    word_o = {rd_f, pad_f};
  end
endmodule

// File: rtl/dll_cal_seq.sv
module dll_cal_seq
  import dll_cal_pkg::*;
#(
  parameter int CLK_MHZ    = 100,
  parameter int TIMEOUT_US = 4000,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ddr_mode_i,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  output logic [1:0]        bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [8:0]        bus_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);
  localparam int LIMIT   = CLK_MHZ * TIMEOUT_US;
  localparam int FIELD_W = 8;

  seq_state_t state_q, state_d;
  logic done_q, done_d, tmo_q, tmo_d;
  logic [FIELD_W-2:0] pad_q;
  logic pad_en;
  logic accept, locked, expired;
  logic [2*FIELD_W-1:0] delay_word;

  assign accept = (state_q == ST_IDLE) && start_i && ddr_mode_i;
  assign locked = bus_rdata_i[8];

  dll_poll_timer #(.LIMIT(LIMIT)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (state_q == ST_CTRL),
    .run_i    ((state_q == ST_POLL) || (state_q == ST_CHECK)),
    .expired_o(expired)
  );

  dll_delay_calc #(.FIELD_W(FIELD_W)) i_calc (
    .pad_i (pad_q),
    .word_o(delay_word)
  );

  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    tmo_d   = tmo_q;
    pad_en  = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_MODE;
        done_d  = 1'b0;
        tmo_d   = 1'b0;
      end
      ST_MODE:  state_d = ST_CTRL;
      ST_CTRL:  state_d = ST_POLL;
      ST_POLL:  state_d = ST_CHECK;
      ST_CHECK: begin
        if (locked) begin
          pad_en  = 1'b1;
          state_d = ST_DELAY;
        end else if (expired) begin
          tmo_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_POLL;
        end
      end
      ST_DELAY: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      tmo_q   <= tmo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pad_q <= '0;
    else if (pad_en) pad_q <= bus_rdata_i[FIELD_W-1:1];
  end

  always_comb begin
    bus_wr_o    = 1'b0;
    bus_rd_o    = 1'b0;
    bus_addr_o  = REG_MODE;
    bus_wdata_o = '0;
    case (state_q)
      ST_MODE: begin
        bus_wr_o    = 1'b1;
        bus_addr_o  = REG_MODE;
        bus_wdata_o = DATA_W'(1);
      end
      ST_CTRL: begin
        bus_wr_o    = 1'b1;
        bus_addr_o  = REG_CTRL;
        bus_wdata_o = DATA_W'(CTRL_WORD);
      end
      ST_POLL: begin
        bus_rd_o    = 1'b1;
        bus_addr_o  = REG_LOCK;
      end
      ST_DELAY: begin
        bus_wr_o    = 1'b1;
        bus_addr_o  = REG_DELAY;
        bus_wdata_o = DATA_W'(delay_word);
      end
      default: ;
    endcase
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = tmo_q;

  p_delay_after_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_o && bus_addr_o == REG_DELAY) |-> $past(bus_rdata_i[8]));
  p_delay_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_o && bus_addr_o == REG_DELAY) |->
      (bus_wdata_o[7:0] == 8'($past(bus_rdata_i[7:0]) >> 1)) &&
      (bus_wdata_o[15:8] == bus_wdata_o[7:0] + 8'd1));
  p_timeout_no_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> !$past(bus_rdata_i[8]) && !busy_o);
  p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o));
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_wr_o, bus_rd_o}));
  p_ctrl_follows_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_o && bus_addr_o == REG_MODE) |=> (bus_wr_o && bus_addr_o == REG_CTRL));
endmodule

// File: tb/test_dll_cal_seq.sv
module test_dll_cal_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TB_MHZ = 1;
  localparam int TB_US  = 40;
  localparam int LIMIT  = TB_MHZ * TB_US;
  localparam logic [31:0] CTRL_EXP = 32'h3F0101C8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic ddr_mode_i = 1'b0;
  logic bus_wr_o, bus_rd_o, busy_o, done_o, timeout_o;
  logic [1:0] bus_addr_o;
  logic [31:0] bus_wdata_o;
  logic [8:0] bus_rdata_i;

  int checks = 0;
  int errors = 0;

  // DLL model
  int lock_after = 0;
  logic [7:0] lock_val = 8'h00;
  int polls = 0;
  // bus log
  int wr_n = 0;
  int rd_n = 0;
  int mode_wr_n = 0;
  logic [1:0]  wr_addr [0:7];
  logic [31:0] wr_data [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  dll_cal_seq #(.CLK_MHZ(TB_MHZ), .TIMEOUT_US(TB_US), .DATA_W(32)) i_dll_cal_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ddr_mode_i(ddr_mode_i),
    .bus_wr_o(bus_wr_o), .bus_rd_o(bus_rd_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  always @(posedge clk) begin
    if (bus_rd_o) begin
      if (polls >= lock_after) bus_rdata_i <= {1'b1, lock_val};
      else                     bus_rdata_i <= {1'b0, ~lock_val};
      polls <= polls + 1;
      rd_n  <= rd_n + 1;
    end
    if (bus_wr_o) begin
      if (wr_n < 8) begin
        wr_addr[wr_n] <= bus_addr_o;
        wr_data[wr_n] <= bus_wdata_o;
      end
      wr_n <= wr_n + 1;
      if (bus_addr_o == 2'd0) mode_wr_n <= mode_wr_n + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk);
    wr_n = 0; rd_n = 0; polls = 0; mode_wr_n = 0;
  endtask

  task automatic pulse_start(input logic ddr);
    @(negedge clk);
    start_i = 1'b1; ddr_mode_i = ddr;
    @(negedge clk);
    start_i = 1'b0; ddr_mode_i = 1'b0;
  endtask

  task automatic wait_idle(output int cycles);
    cycles = 0;
    while (busy_o && cycles < 2000) begin
      @(negedge clk); cycles++;
    end
    if (busy_o) begin
      checks++; errors++;
      $display("FAIL watchdog: block still busy");
    end
  endtask

  task automatic run_lock(input string tag, input int after, input logic [7:0] lv);
    int cyc;
    logic [7:0] pad;
    clear_log();
    lock_after = after; lock_val = lv;
    pulse_start(1'b1);
    wait_idle(cyc);
    pad = {1'b0, lv[7:1]};
    check({tag, " R3 first write addr"}, 32'(wr_addr[0]), 32'd0);
    check({tag, " R3 first write data"}, wr_data[0], 32'd1);
    check({tag, " R4 ctrl addr"}, 32'(wr_addr[1]), 32'd1);
    check({tag, " R4 ctrl word"}, wr_data[1], CTRL_EXP);
    check({tag, " R5 poll count"}, 32'(rd_n), 32'(after + 1));
    check({tag, " R6 delay addr"}, 32'(wr_addr[2]), 32'd3);
    check({tag, " R6 delay word"}, wr_data[2], {16'h0, pad + 8'd1, pad});
    check({tag, " R6 write count"}, 32'(wr_n), 32'd3);
    check({tag, " R6 done"}, 32'(done_o), 32'd1);
    check({tag, " R8 timeout clear"}, 32'(timeout_o), 32'd0);
  endtask

  task automatic t_reset();
    check("R1 busy", 32'(busy_o), 0);
    check("R1 done", 32'(done_o), 0);
    check("R1 timeout", 32'(timeout_o), 0);
    check("R1 strobes", 32'({bus_wr_o, bus_rd_o}), 0);
  endtask

  task automatic t_no_ddr();
    logic d0, t0;
    d0 = done_o; t0 = timeout_o;
    clear_log();
    pulse_start(1'b0);
    repeat (5) @(negedge clk);
    check("R2 no bus access", 32'(wr_n + rd_n), 0);
    check("R2 idle", 32'(busy_o), 0);
    check("R2 flags kept", 32'({done_o, timeout_o}), 32'({d0, t0}));
  endtask

  task automatic t_timeout();
    int cyc;
    clear_log();
    lock_after = 1000000; lock_val = 8'h55;
    pulse_start(1'b1);
    check("R8 done cleared at start", 32'(done_o), 0);
    wait_idle(cyc);
    check("R7 timeout set", 32'(timeout_o), 1);
    check("R7 done low", 32'(done_o), 0);
    checks++;
    if (cyc < LIMIT || cyc > LIMIT + 8) begin
      errors++;
      $display("FAIL R7 timeout window: actual %0d expected %0d..%0d", cyc, LIMIT, LIMIT + 8);
    end
    check("R7 no delay write", 32'(wr_n), 2);
  endtask

  task automatic t_busy_start();
    int cyc;
    clear_log();
    lock_after = 3; lock_val = 8'h10;
    pulse_start(1'b1);
    pulse_start(1'b1);
    repeat (2) @(negedge clk);
    pulse_start(1'b1);
    wait_idle(cyc);
    repeat (4) @(negedge clk);
    check("R9 single mode write", 32'(mode_wr_n), 1);
    check("R9 total writes", 32'(wr_n), 3);
    check("R9 done", 32'(done_o), 1);
  endtask

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_ddr();
        run_lock("A", 0, 8'hA6);
        t_no_ddr();
        run_lock("B", 4, 8'hFF);
        t_timeout();
        t_no_ddr();
        run_lock("C", 2, 8'h01);
        t_busy_start();
      end
      begin
        repeat (100000) @(posedge clk);
        wd = 1;
      end
    join_any
    disable fork;
    if (wd != 0) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule